// File: doc/BRIEF.md
# Tagged Entry Packing Buffer

This block sits between a 32-bit host register port and a serial engine that moves 16-bit tagged entries out and plain bytes in. When the host writes a 32-bit word, the block splits it into two outgoing entries. When the host reads, it combines two received bytes into one 32-bit word. Separate controls can turn off splitting and combining, so that each host access moves exactly one entry or one byte.

Each direction has a transfer counter that the host programs. Completion is flagged when the counter reaches zero. The counter register that takes effect depends on the direction's mode: one register is used in FIFO mode, another in block mode. In block mode, a service request is raised every time one block of entries or bytes has moved. In FIFO mode, the service request comes with completion. Fill-level flags let software pace itself. A data-port write while the output side is full is dropped and recorded as an overflow. A data-port read while the input side is empty returns zero and is recorded as an underflow. A single interrupt line is the OR of every service, done and error flag.

Top module: `tag_pack_fifo`

## Requirements
- R1: With splitting enabled (mode bit 14), a data-port write (address 6) delivers host bits [15:0] to the engine first and bits [31:16] second.
- R2: When exactly one programmed output entry remains unwritten, a split write queues only bits [15:0]; with no count remaining, both halves are queued.
- R3: With combining enabled (mode bit 15), a data-port read returns the older byte in bits [7:0] and the next byte in bits [23:16], with all other bits zero. If only one byte is held, bits [31:8] are zero.
- R4: With splitting disabled, a data-port write queues one entry (bits [15:0]). With combining disabled, a data-port read removes one byte and returns it in bits [7:0].
- R5: Status (address 1) shows output-not-empty at bit 4, input-not-empty at bit 5, and output-full at bit 6. Output-full means fewer than two free entries.
- R6: A data-port write while output-full is set is dropped and sets error bit 0 (address 7).
- R7: A data-port read while the input is empty returns zero and sets error bit 1.
- R8: When the output count reaches zero through engine transfers, status bit 10 is set. When the input count reaches zero, status bit 11 is set. Either one raises `irq`. Loading a count clears that direction's done bit.
- R9: Mode bit 10 (output) and bit 12 (input) select block mode. In FIFO mode, the count is taken from address 2 (output) or 4 (input). In block mode, it is taken from address 3 or 5. A write to the address that is not selected has no effect.
- R10: In block mode, the service bit (status bit 8 output, bit 9 input) is set each time 4 entries (the default block) have moved. In FIFO mode, it is set when the count reaches zero.
- R11: Writing 1 to status bits 8 to 11 clears them, and writing 1 to error bits 0 and 1 clears them. Zero bits leave flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe; a data-port read pops on the clock edge |
| host_addr | input | 3 | Register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from address |
| irq | output | 1 | OR of service, done and error flags |
| eng_out_valid | output | 1 | An output entry is available |
| eng_out_ready | input | 1 | Engine accepts the output entry |
| eng_out_entry | output | 16 | Oldest output entry |
| eng_in_valid | input | 1 | Engine offers a received byte |
| eng_in_ready | output | 1 | Input buffer has room |
| eng_in_byte | input | 8 | Received byte |

## Verification
A register write, or an engine handshake, takes effect at the next rising edge, and the resulting flags and engine outputs can be seen in the same cycle after that edge. Read data is combinational and refers to the state before the popping edge. The bench drives every access on a falling edge. It samples read data shortly after driving the address, and it samples flags and engine outputs on the falling edge that follows the updating rising edge. When the engine stub collects an entry on a falling edge, that entry is the one consumed at the next rising edge. This keeps the collected order exactly equal to the handshake order.

// File: rtl/tpf_pkg.sv
// Package: shared address map, flag positions and size derivation for the
// tagged entry packing buffer. Assumes block-size codes 0..2.
package tpf_pkg;

    typedef enum logic [2:0] {
        A_MODE    = 3'd0,
        A_STATUS  = 3'd1,
        A_OCNT_FF = 3'd2,
        A_OCNT_BK = 3'd3,
        A_ICNT_FF = 3'd4,
        A_ICNT_BK = 3'd5,
        A_DATA    = 3'd6,
        A_ERR     = 3'd7
    } tpf_addr_e;

    localparam int B_OUT_NE   = 4;
    localparam int B_IN_NE    = 5;
    localparam int B_OUT_FULL = 6;
    localparam int B_OUT_SVC  = 8;
    localparam int B_IN_SVC   = 9;
    localparam int B_OUT_DONE = 10;
    localparam int B_IN_DONE  = 11;

    localparam int M_OUT_BLK = 10;
    localparam int M_IN_BLK  = 12;
    localparam int M_UNPACK  = 14;
    localparam int M_PACK    = 15;

    // Block size in words for a size code.
    function automatic int blk_words(input int code);
        return (code == 0) ? 4 : (code == 1) ? 16 : 32;
    endfunction

endpackage

// File: rtl/tpf_pair_fifo.sv
// Module: synchronous FIFO that can accept up to two items and release up
// to two items per cycle. Assumes DEPTH is a power of two and that the
// caller never pushes beyond free space or pops beyond the fill level.
module tpf_pair_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    push_n,
    input  logic [W-1:0]  push_d0,
    input  logic [W-1:0]  push_d1,
    input  logic [1:0]    pop_n,
    output logic [W-1:0]  head0,
    output logic [W-1:0]  head1,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    // Storage write: first item at the write pointer, second just after it.
    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wp] <= push_d0;
        if (push_n == 2'd2) mem[wp + AW'(1)] <= push_d1;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            wp    <= wp + AW'(push_n);
            rp    <= rp + AW'(pop_n);
            level <= level + LW'(push_n) - LW'(pop_n);
        end
    end

    assign head0 = mem[rp];
    assign head1 = mem[rp + AW'(1)];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (LW'(push_n) + level <= LW'(DEPTH) + LW'(pop_n))) else $error("push beyond room"); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (LW'(pop_n) <= level)) else $error("pop beyond level"); // R7
endmodule

// File: rtl/tpf_xfer_track.sv
// Module: per-direction transfer tracker. Counts remaining items down on
// each engine handshake, flags done at zero, and raises a service request
// per block (block mode) or at done (FIFO mode). Assumes BLK power of two.
module tpf_xfer_track #(
    parameter int CNT_W = 16,
    parameter int BLK   = 4,
    localparam int BW   = (BLK > 1) ? $clog2(BLK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_mode,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic             clr_svc,
    input  logic             clr_done,
    output logic             svc,
    output logic             done
);
    logic [CNT_W-1:0] left;
    logic [BW-1:0]    blk_cnt;
    logic             last, wrap;

    assign last = step && (left == CNT_W'(1)) && !load;
    assign wrap = step && (blk_cnt == BW'(BLK - 1)) && !load;

    // Remaining count and position inside the current block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left    <= '0;
            blk_cnt <= '0;
        end else if (load) begin
            left    <= load_val;
            blk_cnt <= '0;
        end else if (step) begin
            if (left != '0) left <= left - CNT_W'(1);
            blk_cnt <= wrap ? '0 : blk_cnt + BW'(1);
        end
    end

    // Done and service flags: set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            svc  <= 1'b0;
        end else begin
            if (load)          done <= 1'b0;
            else if (last)     done <= 1'b1;
            else if (clr_done) done <= 1'b0;
            if (blk_mode ? wrap : last) svc <= 1'b1;
            else if (clr_svc)           svc <= 1'b0;
        end
    end

    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && left == CNT_W'(1)) |=> done) else $error("done missing"); // R8
    AST_SVC_PER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && step && !load && blk_cnt == BW'(BLK - 1)) |=> svc) else $error("svc missing"); // R10
endmodule

// File: rtl/tag_pack_fifo.sv
// Module: host-side split/combine buffer between a 32-bit register port and
// a 16-bit-entry / byte serial engine. Holds mode, counters, flags and
// errors. Assumes one host access per cycle (write or read).
module tag_pack_fifo #(
    parameter int BLK_CODE  = 0,
    parameter int FIFO_CODE = 1,
    parameter int CNT_W     = 16,
    localparam int BLK      = tpf_pkg::blk_words(BLK_CODE),
    localparam int DEPTH    = BLK * (2 << FIFO_CODE),
    localparam int LW       = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [2:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        irq,
    output logic        eng_out_valid,
    input  logic        eng_out_ready,
    output logic [15:0] eng_out_entry,
    input  logic        eng_in_valid,
    output logic        eng_in_ready,
    input  logic [7:0]  eng_in_byte
);
    import tpf_pkg::*;

    logic             out_blk, in_blk, unpack_en, pack_en;
    logic [1:0]       err_q;
    logic [CNT_W-1:0] wr_left;
    logic [LW-1:0]    out_level, in_level;
    logic [15:0]      out_head1;
    logic [7:0]       in_head0, in_head1;
    logic [1:0]       out_push_n, in_pop_n;
    logic             wr_data, rd_data, out_full, out_pop, in_push;
    logic             out_ld, in_ld, status_wr;
    logic             out_svc, out_done, in_svc, in_done;

    assign wr_data   = host_wr && host_addr == A_DATA;
    assign rd_data   = host_rd && host_addr == A_DATA;
    assign status_wr = host_wr && host_addr == A_STATUS;
    assign out_full  = out_level > LW'(DEPTH - 2);
    assign out_pop   = eng_out_valid && eng_out_ready;
    assign in_push   = eng_in_valid && eng_in_ready;
    assign out_ld    = host_wr && ((host_addr == A_OCNT_FF && !out_blk) ||
                                   (host_addr == A_OCNT_BK &&  out_blk));
    assign in_ld     = host_wr && ((host_addr == A_ICNT_FF && !in_blk) ||
                                   (host_addr == A_ICNT_BK &&  in_blk));

    // Output split: two entries unless splitting is off or one entry remains.
    always_comb begin
        out_push_n = 2'd0;
        if (wr_data && !out_full)
            out_push_n = (unpack_en && wr_left != CNT_W'(1)) ? 2'd2 : 2'd1;
    end

    // Input combine: number of bytes a data-port read removes.
    always_comb begin
        in_pop_n = 2'd0;
        if (rd_data && in_level != '0)
            in_pop_n = (pack_en && in_level >= LW'(2)) ? 2'd2 : 2'd1;
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {out_blk, in_blk, unpack_en, pack_en} <= '0;
        end else if (host_wr && host_addr == A_MODE) begin
            out_blk   <= host_wdata[M_OUT_BLK];
            in_blk    <= host_wdata[M_IN_BLK];
            unpack_en <= host_wdata[M_UNPACK];
            pack_en   <= host_wdata[M_PACK];
        end
    end

    // Entries still to be written by the host for the current output count.
    always_ff @(posedge clk) begin
        if (!rst_n)                wr_left <= '0;
        else if (out_ld)           wr_left <= host_wdata[CNT_W-1:0];
        else if (out_push_n != '0) wr_left <= (wr_left > CNT_W'(out_push_n)) ?
                                              wr_left - CNT_W'(out_push_n) : '0;
    end

    // Error flags: overflow bit 0, underflow bit 1, write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else begin
            err_q[0] <= (wr_data && out_full) ||
                        (err_q[0] && !(host_wr && host_addr == A_ERR && host_wdata[0]));
            err_q[1] <= (rd_data && in_level == '0) ||
                        (err_q[1] && !(host_wr && host_addr == A_ERR && host_wdata[1]));
        end
    end

    tpf_pair_fifo #(.W(16), .DEPTH(DEPTH)) u_out_fifo (
        .clk(clk), .rst_n(rst_n), .push_n(out_push_n),
        .push_d0(host_wdata[15:0]), .push_d1(host_wdata[31:16]),
        .pop_n({1'b0, out_pop}), .head0(eng_out_entry), .head1(out_head1),
        .level(out_level));

    tpf_pair_fifo #(.W(8), .DEPTH(DEPTH)) u_in_fifo (
        .clk(clk), .rst_n(rst_n), .push_n({1'b0, in_push}),
        .push_d0(eng_in_byte), .push_d1(8'h00),
        .pop_n(in_pop_n), .head0(in_head0), .head1(in_head1),
        .level(in_level));

    tpf_xfer_track #(.CNT_W(CNT_W), .BLK(BLK)) u_out_track (
        .clk(clk), .rst_n(rst_n), .blk_mode(out_blk), .load(out_ld),
        .load_val(host_wdata[CNT_W-1:0]), .step(out_pop),
        .clr_svc(status_wr && host_wdata[B_OUT_SVC]),
        .clr_done(status_wr && host_wdata[B_OUT_DONE]),
        .svc(out_svc), .done(out_done));

    tpf_xfer_track #(.CNT_W(CNT_W), .BLK(BLK)) u_in_track (
        .clk(clk), .rst_n(rst_n), .blk_mode(in_blk), .load(in_ld),
        .load_val(host_wdata[CNT_W-1:0]), .step(in_push),
        .clr_svc(status_wr && host_wdata[B_IN_SVC]),
        .clr_done(status_wr && host_wdata[B_IN_DONE]),
        .svc(in_svc), .done(in_done));

    assign eng_out_valid = out_level != '0;
    assign eng_in_ready  = in_level != LW'(DEPTH);
    assign irq = out_svc | in_svc | out_done | in_done | (|err_q);

    // Host read mux.
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            A_MODE:   host_rdata = {16'h0, pack_en, unpack_en, 1'b0, in_blk,
                                    1'b0, out_blk, 10'h0};
            A_STATUS: host_rdata = {20'h0, in_done, out_done, in_svc, out_svc,
                                    1'b0, out_full, in_level != '0,
                                    eng_out_valid, 4'h0};
            A_DATA:   if (in_pop_n == 2'd2)
                          host_rdata = {8'h0, in_head1, 8'h0, in_head0};
                      else if (in_level != '0)
                          host_rdata = {24'h0, in_head0};
            A_ERR:    host_rdata = {30'h0, err_q};
            default:  host_rdata = '0;
        endcase
    end

    AST_ENTRY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_pop && out_level >= LW'(2)) |=> eng_out_entry == $past(out_head1)) else $error("order"); // R1
    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && out_full && !out_pop) |=> out_level == $past(out_level)) else $error("not dropped"); // R6
    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && in_level == '0) |-> host_rdata == 32'h0) else $error("empty read"); // R7
endmodule

// File: tb/tag_pack_fifo_bench.sv
// Bench: directed corner cases plus seeded random rounds, with expected
// values built by bench code from the requirements.
module tag_pack_fifo_bench;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        host_wr = 0, host_rd = 0;
    logic [2:0]  host_addr = 0;
    logic [31:0] host_wdata = 0, host_rdata;
    logic        irq, eng_out_valid, eng_out_ready = 0, eng_in_valid = 0, eng_in_ready;
    logic [15:0] eng_out_entry;
    logic [7:0]  eng_in_byte = 0;
    int          checks = 0, errors = 0;
    bit          finished = 0;
    logic [15:0] exp_q[$];

    tag_pack_fifo u_tag_pack_fifo (.*);

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        host_rd = 1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 0;
    endtask

    task automatic feed(input logic [7:0] b);
        eng_in_valid = 1; eng_in_byte = b;
        @(negedge clk);
        eng_in_valid = 0;
    endtask

    // Collect n entries from the engine side and compare against exp_q.
    task automatic drain(input int n, input string req);
        int got = 0;
        int guard = 0;
        eng_out_ready = 1;
        while (got < n && guard < 200) begin
            if (eng_out_valid) begin
                logic [15:0] e = exp_q.pop_front();
                chk(eng_out_entry == e, req, {16'h0, eng_out_entry}, {16'h0, e});
                got++;
            end
            guard++;
            @(negedge clk);
        end
        eng_out_ready = 0;
        chk(got == n, req, got, n);
    endtask

    // Expected entries for a host word given the entries still unwritten.
    function automatic int push_word(input logic [31:0] w, input int left, input bit split);
        exp_q.push_back(w[15:0]);
        if (split && left != 1) begin
            exp_q.push_back(w[31:16]);
            return 2;
        end
        return 1;
    endfunction

    function automatic logic [31:0] pack2(input logic [7:0] b0, input logic [7:0] b1);
        return {8'h0, b1, 8'h0, b0};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] w;
        logic [7:0]  bytes[16];
        int left, n, seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // Reset state: R5 flags clear, R8 no interrupt.
        reg_rd(3'd1, r); chk(r == 0, "R5 reset status", r, 0);
        reg_rd(3'd7, r); chk(r == 0, "R6 reset errors", r, 0);
        chk(irq == 0 && eng_out_valid == 0 && eng_in_ready == 1, "R8 reset outputs",
            {irq, eng_out_valid, eng_in_ready}, 3'b001);

        // Directed odd count: R1, R2, R8, R10 (FIFO-mode service at done).
        reg_wr(3'd0, 32'h0000_C000);
        reg_wr(3'd2, 32'd5);
        left = 5;
        for (int i = 0; i < 3; i++) begin
            w = 32'hA000_0000 + i * 32'h0011_0101;
            left -= push_word(w, left, 1);
            reg_wr(3'd6, w);
        end
        reg_rd(3'd1, r); chk(r[4] == 1, "R5 out-not-empty", r, 32'h10);
        drain(5, "R1 R2 split order");
        chk(eng_out_valid == 0, "R2 no extra half", eng_out_valid, 0);
        reg_rd(3'd1, r); chk(r[10] && r[8], "R8 R10 out done and service", r, 32'h500);
        chk(irq == 1, "R8 irq", irq, 1);
        reg_wr(3'd1, 32'h0000_0500);
        reg_rd(3'd1, r); chk(r == 0, "R11 status clear", r, 0);

        // Random output rounds: R1, R2, R8.
        for (int k = 0; k < 6; k++) begin
            n = 1 + $urandom % 12;
            reg_wr(3'd2, n);
            left = n;
            while (left > 0) begin
                w = $urandom;
                left -= push_word(w, left, 1);
                reg_wr(3'd6, w);
            end
            drain(n, "R1 R2 random split");
            reg_rd(3'd1, r); chk(r[10] == 1, "R8 random done", r, 32'h400);
        end

        // Random input rounds: R3, R8.
        for (int k = 0; k < 5; k++) begin
            n = 1 + $urandom % 10;
            reg_wr(3'd4, n);
            for (int i = 0; i < n; i++) begin
                bytes[i] = 8'($urandom);
                feed(bytes[i]);
            end
            reg_rd(3'd1, r); chk(r[11] == 1 && r[5] == 1, "R8 R5 in done, not empty", r, 32'h820);
            for (int i = 0; i < n; i += 2) begin
                reg_rd(3'd6, r);
                if (i + 1 < n) chk(r == pack2(bytes[i], bytes[i+1]), "R3 combine", r, pack2(bytes[i], bytes[i+1]));
                else           chk(r == {24'h0, bytes[i]}, "R3 single byte", r, {24'h0, bytes[i]});
            end
        end

        // Underflow: R7, then R11 error clear.
        reg_rd(3'd6, r); chk(r == 0, "R7 empty read zero", r, 0);
        reg_rd(3'd7, r); chk(r == 32'h2, "R7 underflow flag", r, 2);
        reg_wr(3'd7, 32'h2);
        reg_rd(3'd7, r); chk(r == 0, "R11 error clear", r, 0);

        // Overflow: R5 full flag, R6 drop.
        reg_wr(3'd1, 32'hF00);
        reg_wr(3'd2, 32'd40);
        for (int i = 0; i < 8; i++) begin
            w = $urandom;
            void'(push_word(w, 40, 1));
            reg_wr(3'd6, w);
        end
        reg_rd(3'd1, r); chk(r[6] == 1, "R5 out-full", r, 32'h40);
        reg_wr(3'd6, 32'hDEAD_BEEF);
        reg_rd(3'd7, r); chk(r == 32'h1, "R6 overflow flag", r, 1);
        drain(16, "R6 dropped word absent");
        chk(eng_out_valid == 0, "R6 nothing extra", eng_out_valid, 0);
        reg_wr(3'd7, 32'h1);

        // Splitting and combining off: R4.
        reg_wr(3'd0, 32'h0);
        reg_wr(3'd2, 32'd3);
        for (int i = 0; i < 3; i++) begin
            w = $urandom;
            void'(push_word(w, 3, 0));
            reg_wr(3'd6, w);
        end
        drain(3, "R4 one entry per write");
        reg_wr(3'd4, 32'd2);
        feed(8'h5A); feed(8'hC3);
        reg_rd(3'd6, r); chk(r == 32'h5A, "R4 one byte per read", r, 32'h5A);
        reg_rd(3'd6, r); chk(r == 32'hC3, "R4 second byte", r, 32'hC3);

        // Block mode output: R9, R10, R11.
        reg_wr(3'd0, 32'h0000_C400);
        reg_wr(3'd1, 32'hF00);
        reg_wr(3'd3, 32'd8);
        for (int i = 0; i < 4; i++) begin
            w = $urandom;
            void'(push_word(w, 8, 1));
            reg_wr(3'd6, w);
        end
        drain(4, "R10 first block");
        reg_rd(3'd1, r); chk(r[8] == 1 && r[10] == 0, "R10 block service", r, 32'h110);
        reg_wr(3'd1, 32'h100);
        reg_rd(3'd1, r); chk(r[8] == 0, "R11 service clear", r, 32'h10);
        drain(4, "R10 second block");
        reg_rd(3'd1, r); chk(r[8] == 1 && r[10] == 1, "R9 R10 block count done", r, 32'h500);
        reg_wr(3'd2, 32'd1);
        reg_rd(3'd1, r); chk(r[10] == 1, "R9 unselected count ignored", r, 32'h400);
        w = 32'h1234_5678;
        void'(push_word(w, 0, 1));
        reg_wr(3'd6, w);
        drain(2, "R9 both halves after ignored count");

        // Block mode input: R9, R10.
        reg_wr(3'd0, 32'h0000_D000);
        reg_wr(3'd4, 32'd1);
        reg_wr(3'd5, 32'd6);
        for (int i = 0; i < 4; i++) feed(8'(i + 1));
        reg_rd(3'd1, r); chk(r[9] == 1 && r[11] == 0, "R9 R10 input block service", r, 32'h220);
        feed(8'h05); feed(8'h06);
        reg_rd(3'd1, r); chk(r[11] == 1, "R9 input block count done", r, 32'h800);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule